// File: doc/BRIEF.md
# Multi-Channel PWM with Staged Updates

This block drives up to sixteen pulse-width outputs from one shared period counter. Each channel holds a rise point, a fall point and an enable bit. Its output is high while the shared counter sits in the half-open window from rise to fall. A small word-wide register port writes these settings and reads them back. A read returns the register selected by the address on the previous cycle.

Any channel can be built with staging registers, chosen per channel by a mask parameter. A write to a staged channel's rise or fall point, or to the shared period, goes into a staging copy and does not touch the waveform. Software then writes the sync register. At the next period boundary every staged value moves into the active copy at once. Until that boundary the sync register reads 1. Channels built without staging take their writes at once and ignore the sync request. Readback always shows the active values, meaning the ones shaping the output now.

Top module: `pwm_multi`

## Requirements
- R1: After synchronous reset, all enables, the period, all rise and fall points and the sync flag read 0, and every output is low.
- R2: The shared counter runs from 0 up to the active period P and then returns to 0. Every enabled output therefore repeats every P+1 cycles. The cycle in which the counter wraps is the period boundary.
- R3: An enabled output is high while the counter is at least its rise point and below its fall point, so it is high for fall-rise cycles per period. A disabled output stays low.
- R4: Enables live in two bytes. Address 0x00 holds channels 0-7 and address 0x01 holds channels 8-15. A channel's byte is its index shifted right by 3, and its bit in that byte is the index modulo 8.
- R5: Rise and fall points are at address 0x10+2*ch and 0x11+2*ch. On a staged channel a write to either one changes neither the output nor the readback until a sync commit.
- R6: Writing a word with bit 0 set to address 0x03 starts a sync request. That address then reads 1 until the next period boundary. At that boundary all staged values become active and the address reads 0 again.
- R7: On a channel built without staging, writes to its rise or fall point take effect and read back at once, with no sync request.
- R8: The period, at address 0x02, is staged whenever any channel is staged. It reads back its old value and keeps the old cadence until the sync commit.
- R9: Read data is registered. It reflects the address presented on the previous clock edge, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register word address |
| reg_wdata | input | CW | Write data |
| reg_rdata | output | CW | Registered read data |
| pwm_out | output | NCH | Channel outputs, registered |

## Verification
The bench builds the block with 16 channels, a 16-bit counter and a staging mask of 0x00FF. Channels 0-7 are therefore staged and channels 8-15 are direct. Both update paths and both enable bytes can then be exercised in one build. Because one channel is staged, the period is staged too. This lets the bench watch a staged channel keep its old cadence until a commit, while a direct channel changes its pulse width at once under the same timebase.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned ADDR_W = 6;
  localparam logic [ADDR_W-1:0] A_EN_LO  = 6'h00;
  localparam logic [ADDR_W-1:0] A_EN_HI  = 6'h01;
  localparam logic [ADDR_W-1:0] A_PERIOD = 6'h02;
  localparam logic [ADDR_W-1:0] A_SYNC   = 6'h03;
  localparam int unsigned       A_DUTY   = 16;
endpackage

// File: rtl/pwm_timebase.sv
module pwm_timebase #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] period_i,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o
);
  logic [CW-1:0] cnt_q;

  assign wrap_o = (cnt_q >= period_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R2: counter returns to zero after reaching the period
  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (cnt_q >= period_i) |=> (cnt_q == '0));
  // R2: counter advances by one below the period
  p_step_r2: assert property (@(posedge clk) disable iff (rst)
    (cnt_q < period_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int unsigned CW       = 16,
  parameter bit          SHADOWED = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_rise_i,
  input  logic          wr_fall_i,
  input  logic [CW-1:0] wdata_i,
  input  logic          commit_i,
  input  logic          en_i,
  input  logic [CW-1:0] cnt_i,
  output logic [CW-1:0] rise_o,
  output logic [CW-1:0] fall_o,
  output logic          pwm_o
);
  logic [CW-1:0] rise_q, fall_q;

  generate
    if (SHADOWED) begin : g_staged
      logic [CW-1:0] rise_s, fall_s;
      always_ff @(posedge clk) begin
        if (rst) begin
          rise_s <= '0; fall_s <= '0; rise_q <= '0; fall_q <= '0;
        end else begin
          if (wr_rise_i) rise_s <= wdata_i;
          if (wr_fall_i) fall_s <= wdata_i;
          if (commit_i) begin
            rise_q <= rise_s;
            fall_q <= fall_s;
          end
        end
      end
      // R5: active points only move on a commit
      p_stage_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !commit_i |=> ($stable(rise_q) && $stable(fall_q)));
    end else begin : g_direct
      always_ff @(posedge clk) begin
        if (rst) begin
          rise_q <= '0; fall_q <= '0;
        end else begin
          if (wr_rise_i) rise_q <= wdata_i;
          if (wr_fall_i) fall_q <= wdata_i;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) pwm_o <= 1'b0;
    else     pwm_o <= en_i && (cnt_i >= rise_q) && (cnt_i < fall_q);
  end

  assign rise_o = rise_q;
  assign fall_o = fall_q;

  // R3: a disabled channel drives low
  p_off_low_r3: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !pwm_o);
endmodule

// File: rtl/pwm_multi.sv
module pwm_multi
  import pwm_pkg::*;
#(
  parameter int unsigned NCH         = 16,
  parameter int unsigned CW          = 16,
  parameter logic [15:0] SHADOW_MASK = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [CW-1:0]     reg_wdata,
  output logic [CW-1:0]     reg_rdata,
  output logic [NCH-1:0]    pwm_out
);
  localparam bit ANY_SH = |SHADOW_MASK[NCH-1:0];

  logic [NCH-1:0] en_q;
  logic [15:0]    en_all;
  logic [CW-1:0]  period_q;
  logic [CW-1:0]  cnt;
  logic           wrap;
  logic           sync_q;
  logic           sync_set;
  logic           commit;
  logic [CW-1:0]  rise_v [NCH];
  logic [CW-1:0]  fall_v [NCH];
  logic [CW-1:0]  rd_next;

  assign en_all   = 16'(en_q);
  assign sync_set = reg_we && (reg_addr == A_SYNC) && reg_wdata[0];
  assign commit   = sync_q && wrap;

  // enable bytes: byte = index >> 3, bit = index % 8
  always_ff @(posedge clk) begin
    if (rst) en_q <= '0;
    else if (reg_we) begin
      for (int i = 0; i < NCH; i++) begin
        if (i < 8 && reg_addr == A_EN_LO)  en_q[i] <= reg_wdata[i % 8];
        if (i >= 8 && reg_addr == A_EN_HI) en_q[i] <= reg_wdata[i % 8];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           sync_q <= 1'b0;
    else if (sync_set) sync_q <= 1'b1;
    else if (wrap)     sync_q <= 1'b0;
  end

  generate
    if (ANY_SH) begin : g_per_staged
      logic [CW-1:0] period_s;
      always_ff @(posedge clk) begin
        if (rst) begin
          period_s <= '0; period_q <= '0;
        end else begin
          if (reg_we && reg_addr == A_PERIOD) period_s <= reg_wdata;
          if (commit) period_q <= period_s;
        end
      end
      // R8: the active period only changes on a commit
      p_period_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(period_q));
    end else begin : g_per_direct
      always_ff @(posedge clk) begin
        if (rst) period_q <= '0;
        else if (reg_we && reg_addr == A_PERIOD) period_q <= reg_wdata;
      end
    end
  endgenerate

  pwm_timebase #(.CW(CW)) u_tb (
    .clk(clk), .rst(rst), .period_i(period_q), .cnt_o(cnt), .wrap_o(wrap)
  );

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_ch
      localparam logic [ADDR_W-1:0] A_R = ADDR_W'(A_DUTY + 2 * g);
      localparam logic [ADDR_W-1:0] A_F = ADDR_W'(A_DUTY + 2 * g + 1);
      pwm_chan #(.CW(CW), .SHADOWED(SHADOW_MASK[g])) u_ch (
        .clk(clk), .rst(rst),
        .wr_rise_i(reg_we && reg_addr == A_R),
        .wr_fall_i(reg_we && reg_addr == A_F),
        .wdata_i(reg_wdata), .commit_i(commit), .en_i(en_q[g]),
        .cnt_i(cnt), .rise_o(rise_v[g]), .fall_o(fall_v[g]),
        .pwm_o(pwm_out[g])
      );
    end
  endgenerate

  always_comb begin
    rd_next = '0;
    case (reg_addr)
      A_EN_LO:  rd_next = CW'(en_all[7:0]);
      A_EN_HI:  rd_next = CW'(en_all[15:8]);
      A_PERIOD: rd_next = period_q;
      A_SYNC:   rd_next = CW'(sync_q);
      default: begin
        for (int i = 0; i < NCH; i++) begin
          if (reg_addr == ADDR_W'(A_DUTY + 2 * i))     rd_next = rise_v[i];
          if (reg_addr == ADDR_W'(A_DUTY + 2 * i + 1)) rd_next = fall_v[i];
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_next;
  end

  // R6: a pending request survives until a boundary
  p_sync_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (sync_q && !wrap) |=> sync_q);
  // R6: the boundary clears a request unless a new one arrives
  p_sync_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (sync_q && wrap && !sync_set) |=> !sync_q);
endmodule

// File: tb/test_pwm_multi.sv
module test_pwm_multi;
  localparam int unsigned NCH = 16;
  localparam int unsigned CW  = 16;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           reg_we = 1'b0;
  logic [5:0]     reg_addr = '0;
  logic [CW-1:0]  reg_wdata = '0;
  logic [CW-1:0]  reg_rdata;
  logic [NCH-1:0] pwm_out;

  int n_run = 0;
  int n_fail = 0;

  logic [CW-1:0] exp_q [$];
  string         tag_q [$];
  logic          rd_req = 1'b0;
  logic          rd_seen = 1'b0;

  always #2 clk = ~clk;

  pwm_multi #(.NCH(NCH), .CW(CW), .SHADOW_MASK(16'h00FF)) i_pwm_multi (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pwm_out(pwm_out)
  );

  function automatic void check(bit ok, string tag, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endfunction

  // monitor: the read issued at one edge is compared at the following negedge
  always @(posedge clk) rd_seen <= rd_req;
  always @(negedge clk) begin
    if (rd_seen && exp_q.size() > 0) begin
      logic [CW-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(reg_rdata === e, t, int'(reg_rdata), int'(e));
    end
  end

  task automatic wr(input logic [5:0] a, input logic [CW-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [CW-1:0] e, input string t);
    @(negedge clk);
    reg_addr = a; rd_req = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic measure(input int ch, input int ew, input int ep, input string t);
    logic prev;
    int w, p, g;
    @(negedge clk); prev = pwm_out[ch];
    g = 0;
    while (g < 2000) begin
      @(negedge clk); g++;
      if (pwm_out[ch] && !prev) break;
      prev = pwm_out[ch];
    end
    w = 1; p = 1; prev = 1'b1;
    while (p < 2000) begin
      @(negedge clk);
      if (pwm_out[ch] && !prev) break;
      if (pwm_out[ch]) w++;
      prev = pwm_out[ch];
      p++;
    end
    check(w == ew, {t, " width"}, w, ew);
    check(p == ep, {t, " period"}, p, ep);
  endtask

  task automatic stay_low(input int ch, input int n, input string t);
    int hi;
    hi = 0;
    repeat (n) begin
      @(negedge clk);
      if (pwm_out[ch]) hi++;
    end
    check(hi == 0, t, hi, 0);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(pwm_out == '0, "R1 outputs", int'(pwm_out), 0);
    rd(6'h00, 0, "R1 enable low");
    rd(6'h01, 0, "R1 enable high");
    rd(6'h02, 0, "R1 period");
    rd(6'h03, 0, "R1 sync");
    rd(6'h10, 0, "R1 rise ch0");
    rd(6'h3F, 0, "R9 unmapped");

    // R8: period staged, R6 commit
    wr(6'h02, 9);
    rd(6'h02, 0, "R8 period before sync");
    wr(6'h03, 1);
    repeat (3) @(negedge clk);
    rd(6'h03, 0, "R6 sync cleared");
    rd(6'h02, 9, "R8 period after sync");

    // R7: direct channel 8
    wr(6'h20, 2);
    wr(6'h21, 6);
    rd(6'h20, 2, "R7 rise ch8 immediate");
    rd(6'h21, 6, "R7 fall ch8 immediate");
    wr(6'h01, 16'h0001);
    rd(6'h01, 16'h0001, "R4 enable high byte");
    measure(8, 4, 10, "R3 R2 ch8");

    // R5: staged channel 3
    wr(6'h16, 1);
    wr(6'h17, 8);
    rd(6'h16, 0, "R5 rise ch3 staged");
    rd(6'h17, 0, "R5 fall ch3 staged");
    wr(6'h00, 16'h0008);
    rd(6'h00, 16'h0008, "R4 enable low byte bit3");
    stay_low(3, 25, "R5 staged ch3 output");

    // R6: pending flag, aligned to counter via ch8 rise
    measure(8, 4, 10, "R2 ch8 align");
    wr(6'h03, 1);
    rd(6'h03, 1, "R6 sync pending");
    repeat (30) @(negedge clk);
    rd(6'h03, 0, "R6 sync after boundary");
    rd(6'h16, 1, "R5 rise ch3 committed");
    rd(6'h17, 8, "R5 fall ch3 committed");
    measure(3, 7, 10, "R3 ch3");

    // R7: direct channel changes width without sync
    wr(6'h21, 7);
    rd(6'h21, 7, "R7 fall ch8 update");
    measure(8, 5, 10, "R7 ch8 new width");

    // R8: staged period keeps old cadence until commit
    wr(6'h02, 19);
    measure(3, 7, 10, "R8 old period");
    rd(6'h02, 9, "R8 period readback staged");
    wr(6'h03, 1);
    repeat (30) @(negedge clk);
    measure(3, 7, 20, "R8 new period");

    // R4: bit 7 of upper byte is channel 15
    wr(6'h2E, 0);
    wr(6'h2F, 5);
    wr(6'h01, 16'h0080);
    measure(15, 5, 20, "R4 ch15");
    stay_low(8, 45, "R3 ch8 disabled");

    repeat (3) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule